// File: doc/BRIEF.md
# UART Interrupt Mask and Command Unit

This block collects the interrupt sources of a UART and presents them to software through a small register port. Edge events from the transmit and receive datapaths arrive as single-cycle pulses and are held in a sticky status word. Each one stays set until software writes the matching channel command. Two level sources are computed every cycle from the FIFO fill counts and two programmable watermarks. A third level source mirrors the clear-to-send pin. A mask register selects which status bits reach the single interrupt line. A write-only command register also turns the receiver and the transmitter on and off.

Software programs the mask and the watermarks. When the interrupt line rises it reads the masked status, serves each source, and writes the command that clears it. Level sources clear themselves when the FIFO levels move back across their watermark. The serial datapaths sit outside the block and feed it pulses and levels.

Top module: `uart_irq_ctl`

## Requirements
- R1: After reset the mask, both watermarks, all sticky status bits, the overrun flag and both channel enables are zero, and irq_o is low.
- R2: Status bit positions are: 0 TX level, 1 RX hunt, 2 RX break change, 3 RX stale, 4 RX level, 5 delta CTS, 6 current CTS, 7 TX ready, 8 TX error, 9 TX done, 10 RX break start, 11 RX break end, 12 parity/frame error. A pulse on ev_i[k], for k in {1,2,3,5,7,8,9,10,11,12}, sets status bit k one cycle later, and the bit holds until a command clears it. ev_i bits 0, 4 and 6 have no effect.
- R3: Status bit 6 follows cts_i in the same cycle.
- R4: Status bit 0 is 1 exactly while tx_level_i is less than or equal to the TX watermark.
- R5: Status bit 4 is 1 exactly while rx_level_i is strictly greater than the RX watermark.
- R6: masked_o equals the raw status ANDed with the mask, and irq_o is 1 exactly when any bit of masked_o is 1.
- R7: A write to the command register (address 1) carries a channel code in data bits [11:4]. Code 0x04 clears bits 2, 10 and 11. Code 0x07 clears bit 5. Code 0x08 clears bit 3. Code 0x30 clears bit 7. Code 0x80 clears bit 8. Code 0x81 clears bit 9.
- R8: A pulse on ovr_i sets a sticky overrun flag. Channel code 0x03 clears that flag and status bit 12.
- R9: Channel code 0x01 resets the receive side: it clears bits 1, 2, 3, 10, 11 and 12, clears the overrun flag and turns the receiver off. Channel code 0x02 resets the transmit side: it clears bits 7, 8 and 9 and turns the transmitter off.
- R10: Command data bits 0, 1, 2 and 3 mean RX on, RX off, TX on and TX off. Within one write, an off bit wins over an on bit, and an on bit wins over a channel reset of the same side.
- R11: When an event pulse and a command that clears the same bit fall in the same cycle, the bit ends up set.
- R12: Read addresses: 0 mask, 2 TX watermark, 3 RX watermark, 4 raw status, 5 masked status, 6 {overrun, TX enable, RX enable} in bits [2:0]. Addresses 1 and 7 read zero. Writes to addresses 4 to 7 have no effect.
- R13: Channel codes not listed in R7 to R9 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_i | input | 13 | Event pulses, one per status bit position |
| ovr_i | input | 1 | Receive overrun pulse |
| cts_i | input | 1 | Current clear-to-send level |
| tx_level_i | input | LVL_W | TX FIFO fill count |
| rx_level_i | input | LVL_W | RX FIFO fill count |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | DATA_W | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | DATA_W | Register read data |
| raw_o | output | 13 | Raw status |
| masked_o | output | 13 | Masked status |
| irq_o | output | 1 | Interrupt request |
| rx_en_o | output | 1 | Receiver enable |
| tx_en_o | output | 1 | Transmitter enable |
| ovr_o | output | 1 | Sticky overrun flag |

## Verification
The assertions check the following on every cycle:
- a TX ready pulse always latches;
- sticky bits stay stable when no event arrives and no command is written;
- the stale clear works;
- an overrun pulse always sets the flag;
- a disable bit always leaves its side off;
- a zero mask keeps the interrupt line low.

Only the bench scenarios can show the rest. These are:
- the full code-to-bit clearing table, including unknown codes;
- the inclusive and exclusive senses of the two watermark compares at equality;
- the priority order between on bits, off bits and channel resets;
- a pulse that lands on the same cycle as its clear.

The bench also compares every read address against a model.

// File: rtl/uart_irq_ctl.sv
module uart_irq_ctl #(
  parameter int FIFO_DEPTH = 64,
  parameter int DATA_W     = 32,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1),
  localparam int NSRC      = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   ev_i,
  input  logic              ovr_i,
  input  logic              cts_i,
  input  logic [LVL_W-1:0]  tx_level_i,
  input  logic [LVL_W-1:0]  rx_level_i,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [2:0]        rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [NSRC-1:0]   raw_o,
  output logic [NSRC-1:0]   masked_o,
  output logic              irq_o,
  output logic              rx_en_o,
  output logic              tx_en_o,
  output logic              ovr_o
);

  localparam logic [2:0] A_MASK = 3'd0, A_CMD = 3'd1, A_TXWM = 3'd2, A_RXWM = 3'd3,
                         A_RAW = 3'd4, A_MSK = 3'd5, A_FLG = 3'd6;
  localparam logic [NSRC-1:0] STICKY = 13'h1FAE;

  logic [NSRC-1:0]  mask_q, sticky_q, clr;
  logic [LVL_W-1:0] txwm_q, rxwm_q;
  logic             rx_en_q, tx_en_q, ovr_q, ovr_clr, rx_rst, tx_rst;

  wire       cmd_wr = wr_en_i && (wr_addr_i == A_CMD);
  wire [7:0] chan   = wr_data_i[11:4];

  always_comb begin
    clr = '0; ovr_clr = 1'b0; rx_rst = 1'b0; tx_rst = 1'b0;
    if (cmd_wr) begin
      case (chan)
        8'h01: begin clr = 13'h1C0E; ovr_clr = 1'b1; rx_rst = 1'b1; end
        8'h02: begin clr = 13'h0380; tx_rst = 1'b1; end
        8'h03: begin clr = 13'h1000; ovr_clr = 1'b1; end
        8'h04: clr = 13'h0C04;
        8'h07: clr = 13'h0020;
        8'h08: clr = 13'h0008;
        8'h30: clr = 13'h0080;
        8'h80: clr = 13'h0100;
        8'h81: clr = 13'h0200;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0; txwm_q <= '0; rxwm_q <= '0; sticky_q <= '0;
      ovr_q <= 1'b0; rx_en_q <= 1'b0; tx_en_q <= 1'b0;
    end else begin
      sticky_q <= (sticky_q & ~clr) | (ev_i & STICKY);
      ovr_q    <= (ovr_q & ~ovr_clr) | ovr_i;
      if (wr_en_i && wr_addr_i == A_MASK) mask_q <= wr_data_i[NSRC-1:0];
      if (wr_en_i && wr_addr_i == A_TXWM) txwm_q <= wr_data_i[LVL_W-1:0];
      if (wr_en_i && wr_addr_i == A_RXWM) rxwm_q <= wr_data_i[LVL_W-1:0];
      if (cmd_wr) begin
        if (wr_data_i[1])      rx_en_q <= 1'b0;
        else if (wr_data_i[0]) rx_en_q <= 1'b1;
        else if (rx_rst)       rx_en_q <= 1'b0;
        if (wr_data_i[3])      tx_en_q <= 1'b0;
        else if (wr_data_i[2]) tx_en_q <= 1'b1;
        else if (tx_rst)       tx_en_q <= 1'b0;
      end
    end
  end

  always_comb begin
    raw_o    = sticky_q;
    raw_o[0] = (tx_level_i <= txwm_q);
    raw_o[4] = (rx_level_i > rxwm_q);
    raw_o[6] = cts_i;
  end

  assign masked_o = raw_o & mask_q;
  assign irq_o    = |masked_o;
  assign rx_en_o  = rx_en_q;
  assign tx_en_o  = tx_en_q;
  assign ovr_o    = ovr_q;

  always_comb begin
    rd_data_o = '0;
    case (rd_addr_i)
      A_MASK: rd_data_o[NSRC-1:0]  = mask_q;
      A_TXWM: rd_data_o[LVL_W-1:0] = txwm_q;
      A_RXWM: rd_data_o[LVL_W-1:0] = rxwm_q;
      A_RAW:  rd_data_o[NSRC-1:0]  = raw_o;
      A_MSK:  rd_data_o[NSRC-1:0]  = masked_o;
      A_FLG:  rd_data_o[2:0]       = {ovr_q, tx_en_q, rx_en_q};
      default: ;
    endcase
  end

  AST_TXRDY_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    ev_i[7] |=> raw_o[7]); // R2
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_wr && ((ev_i & STICKY) == '0)) |=> $stable(sticky_q)); // R2
  AST_STALE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && chan == 8'h08 && !ev_i[3]) |=> !raw_o[3]); // R7
  AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_i |=> ovr_o); // R8
  AST_RX_OFF_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && wr_data_i[1]) |=> !rx_en_o); // R10
  AST_MASK_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq_o); // R6

endmodule

// File: tb/uart_irq_ctl_tb.sv
module uart_irq_ctl_tb;
  localparam int PERIOD = 10;
  localparam int DEPTH  = 64;
  localparam int LW     = $clog2(DEPTH + 1);

  logic clk = 0, rst_n = 0;
  logic [12:0] ev = '0;
  logic ovr = 0, cts = 0;
  logic [LW-1:0] txl = '0, rxl = '0;
  logic we = 0;
  logic [2:0] wa = '0, ra = '0;
  logic [31:0] wd = '0;
  logic [31:0] rd;
  logic [12:0] raw, msk;
  logic irq, rxen, txen, ovro;

  always #(PERIOD/2) clk = ~clk;

  uart_irq_ctl #(.FIFO_DEPTH(DEPTH), .DATA_W(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .ev_i(ev), .ovr_i(ovr), .cts_i(cts),
    .tx_level_i(txl), .rx_level_i(rxl), .wr_en_i(we), .wr_addr_i(wa),
    .wr_data_i(wd), .rd_addr_i(ra), .rd_data_o(rd), .raw_o(raw),
    .masked_o(msk), .irq_o(irq), .rx_en_o(rxen), .tx_en_o(txen), .ovr_o(ovro));

  int checks = 0, errors = 0;
  logic [12:0] m_st, m_mask;
  logic [LW-1:0] m_txwm, m_rxwm;
  logic m_ovr, m_rx, m_tx;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [12:0] clr_of(logic [7:0] c);
    case (c)
      8'h01: return 13'h1C0E;
      8'h02: return 13'h0380;
      8'h03: return 13'h1000;
      8'h04: return 13'h0C04;
      8'h07: return 13'h0020;
      8'h08: return 13'h0008;
      8'h30: return 13'h0080;
      8'h80: return 13'h0100;
      8'h81: return 13'h0200;
      default: return 13'h0;
    endcase
  endfunction

  function automatic logic [12:0] exp_raw();
    logic [12:0] r = m_st;
    r[0] = (txl <= m_txwm);
    r[4] = (rxl > m_rxwm);
    r[6] = cts;
    return r;
  endfunction

  function automatic logic [31:0] exp_rd(logic [2:0] a);
    case (a)
      3'd0: return {19'd0, m_mask};
      3'd2: return 32'(m_txwm);
      3'd3: return 32'(m_rxwm);
      3'd4: return {19'd0, exp_raw()};
      3'd5: return {19'd0, exp_raw() & m_mask};
      3'd6: return {29'd0, m_ovr, m_tx, m_rx};
      default: return 32'd0;
    endcase
  endfunction

  task automatic check_all(string tag);
    logic [12:0] er = exp_raw();
    chk({tag, " R2/R3/R4/R5 raw"}, {19'd0, raw}, {19'd0, er});
    chk({tag, " R6 masked"}, {19'd0, msk}, {19'd0, er & m_mask});
    chk({tag, " R6 irq"}, {31'd0, irq}, {31'd0, |(er & m_mask)});
    chk({tag, " R10 enables"}, {30'd0, txen, rxen}, {30'd0, m_tx, m_rx});
    chk({tag, " R8 ovr"}, {31'd0, ovro}, {31'd0, m_ovr});
    chk({tag, " R12 read"}, rd, exp_rd(ra));
  endtask

  // called at negedge with inputs set; advances one cycle and checks
  task automatic step(string tag);
    logic [12:0] c = '0;
    logic oc = 0;
    logic [7:0] ch = wd[11:4];
    if (we && wa == 3'd1) begin
      c = clr_of(ch);
      oc = (ch == 8'h01) || (ch == 8'h03);
      if (wd[1]) m_rx = 0; else if (wd[0]) m_rx = 1; else if (ch == 8'h01) m_rx = 0;
      if (wd[3]) m_tx = 0; else if (wd[2]) m_tx = 1; else if (ch == 8'h02) m_tx = 0;
    end
    m_st  = (m_st & ~c) | (ev & 13'h1FAE);
    m_ovr = (m_ovr & ~oc) | ovr;
    if (we && wa == 3'd0) m_mask = wd[12:0];
    if (we && wa == 3'd2) m_txwm = wd[LW-1:0];
    if (we && wa == 3'd3) m_rxwm = wd[LW-1:0];
    @(posedge clk); @(negedge clk);
    check_all(tag);
    ev = '0; ovr = 0; we = 0;
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d, string tag);
    we = 1; wa = a; wd = d; step(tag);
  endtask

  bit done = 0;
  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  logic [7:0] codes [12] = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h07, 8'h08,
                             8'h30, 8'h80, 8'h81, 8'h05, 8'h55, 8'h00};

  initial begin
    void'($urandom(32'h1234));
    m_st = '0; m_mask = '0; m_txwm = '0; m_rxwm = '0; m_ovr = 0; m_rx = 0; m_tx = 0;
    txl = 7'd3; rxl = 7'd0;
    #(PERIOD * 3);
    @(negedge clk);
    // R1 reset state (tx level 3 > watermark 0, so all raw bits low)
    chk("R1 raw", {19'd0, raw}, 32'd0);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 flags", {29'd0, ovro, txen, rxen}, 32'd0);
    rst_n = 1;
    @(negedge clk);
    wr(3'd0, 32'h1FFF, "dir mask");
    // R2 latch and hold; ignored ev bits 0,4,6
    ev = 13'h0051; step("R2 ignored ev");
    ev = 13'h0080; step("R2 txrdy set");
    step("R2 txrdy hold");
    // R11 set beats clear
    ev = 13'h0080; wr(3'd1, 32'h300, "R11 set wins");
    wr(3'd1, 32'h300, "R7 txrdy clear");
    // R4/R5 equality boundaries
    wr(3'd2, 32'd5, "R4 txwm"); txl = 7'd5; rxl = 7'd5;
    wr(3'd3, 32'd5, "R5 rxwm eq");
    rxl = 7'd6; txl = 7'd6; step("R4/R5 above");
    // R3 cts
    cts = 1; step("R3 cts high"); cts = 0; step("R3 cts low");
    // R10 priority
    wr(3'd1, 32'h5, "R10 both on");
    wr(3'd1, 32'h3, "R10 rx off wins");
    wr(3'd1, 32'h1 | 32'h10, "R10 on beats rx reset");
    wr(3'd1, 32'h20, "R9 tx reset");
    // R8 overrun
    ovr = 1; ev = 13'h1000; step("R8 ovr set");
    wr(3'd1, 32'h30, "R8 err reset");
    // R13 unknown code, R12 read-only writes
    ev = 13'h1FAE; step("R2 all sticky");
    wr(3'd1, 32'h550, "R13 unknown code");
    wr(3'd5, 32'h0, "R12 ro write");
    wr(3'd1, 32'h10, "R9 rx reset");
    wr(3'd0, 32'h0, "R6 mask zero");
    for (int i = 0; i < 3000; i++) begin
      ev  = 13'($urandom);
      if ($urandom_range(3) != 0) ev = '0;
      ovr = ($urandom_range(7) == 0);
      cts = 1'($urandom);
      txl = 7'($urandom_range(DEPTH));
      rxl = 7'($urandom_range(DEPTH));
      ra  = 3'($urandom);
      we  = ($urandom_range(2) == 0);
      wa  = 3'($urandom);
      if ($urandom_range(1) == 0) wa = 3'd1;
      wd  = $urandom;
      if (wa == 3'd1) wd = {20'd0, codes[$urandom_range(11)], 4'($urandom)};
      if (wa == 3'd2 || wa == 3'd3) wd = 32'($urandom_range(DEPTH));
      step("rnd R7/R9/R13");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule